// File: doc/BRIEF.md
# Configuration Register Space for a 32-bit Bus Target

This block holds the 256-byte configuration space of one target function on a 32-bit parallel bus of the PCI kind. The first 64 bytes form the fixed header. The remaining 192 bytes are a device-specific area, and in this build none of those locations is implemented. The bus front end presents each configuration access as a single-cycle read or write strobe. With the strobe it gives a select level, a byte address, four byte enables and write data. The block claims the access or ignores it. For a claimed access it answers with an acknowledge and, on a read, the addressed dword, one clock later.

The header carries the following registers:
- Fixed identity values, set by parameters.
- A command register. Its bits drive the I/O-space, memory-space, bus-master, parity-response and system-error enables into the rest of the core.
- A status register. Its error flags are raised by one-cycle event inputs and cleared by writing ones.
- A writable interrupt line byte.
- A fixed interrupt pin byte.

Multi-byte registers are little-endian: byte enable n covers data bits 8n+7 to 8n. Byte, 16-bit and 32-bit accesses are therefore all expressed through the byte enables.

Top module: `cfg_space`

## Requirements
- R1: An access is claimed only when `cfg_sel` is high and `cfg_addr[1:0]` is 00. A claimed read or write raises `cfg_ack` for one cycle after the strobe. An unclaimed access gives no acknowledge and changes no register.
- R2: Dword 00h reads {device ID, vendor ID}, with the vendor ID in bits 15:0. Dword 08h reads {class code, revision}, with the revision in bits 7:0. Dword 0Ch reads the header type in bits 23:16 and zero elsewhere.
- R3: Only command bits 0, 1, 2, 6 and 8 are writable, and every other command bit reads 0. Byte enable 0 writes command bits 7:0 and byte enable 1 writes bits 15:8, both at dword 04h. A write with a byte enable low leaves that byte unchanged.
- R4: The enable outputs follow the command register:
  - `io_en` follows bit 0.
  - `mem_en` follows bit 1.
  - `master_en` follows bit 2.
  - `perr_resp_en` follows bit 6.
  - `serr_en` follows bit 8.
- R5: While the command register is 0000h, `fn_active` and all enable outputs are low, and configuration accesses are still claimed. Any nonzero command raises `fn_active`.
- R6: After reset, the following are all 0:
  - the command register, every status error flag and the interrupt line;
  - every enable output, `cfg_ack` and `cfg_rdata`.
- R7: The status error flags are sticky and become visible the cycle after their event pulse. The mapping from `err_set` to status bits is:
  - `err_set[0]` to bit 8;
  - `err_set[1]` to bit 11;
  - `err_set[2]` to bit 12;
  - `err_set[3]` to bit 13;
  - `err_set[4]` to bit 14;
  - `err_set[5]` to bit 15.
- R8: A write to dword 04h with byte enable 3 high clears each status flag whose data bit, in bits 31:24, is 1. Zero data bits leave their flags unchanged.
- R9: If an event pulse and a write-one-to-clear reach the same status flag in the same cycle, the flag ends up set.
- R10: Status bits 10:9 read the `SEL_TIMING` parameter and the other non-flag status bits read 0. Writes to any of these bits are discarded.
- R11: The interrupt line, at dword 3Ch bits 7:0, is read/write through byte enable 0. The interrupt pin, at bits 15:8, is read-only with the value `INT_PIN`, which lies in 0 to 4. Bits 31:16 of that dword read 0.
- R12: Every other header dword and every dword from 40h to FCh reads 0, and writes to them are discarded.
- R13: Writes to the identity dwords 00h and 08h complete with an acknowledge and leave the values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| cfg_sel | input | 1 | Configuration select for this function |
| cfg_rd | input | 1 | Configuration read strobe, one cycle |
| cfg_wr | input | 1 | Configuration write strobe, one cycle |
| cfg_addr | input | 8 | Byte address in configuration space |
| cfg_be | input | 4 | Byte enables, active high |
| cfg_wdata | input | 32 | Write data |
| err_set | input | 6 | Status flag set pulses |
| cfg_rdata | output | 32 | Read data, registered |
| cfg_ack | output | 1 | Access claimed, one cycle after strobe |
| io_en | output | 1 | I/O space response enable |
| mem_en | output | 1 | Memory space response enable |
| master_en | output | 1 | Bus master enable |
| perr_resp_en | output | 1 | Parity error response enable |
| serr_en | output | 1 | System error signalling enable |
| fn_active | output | 1 | Command nonzero; low isolates the function |

## Verification
The assertions take for granted three things about the inputs:
- Read and write strobes never arrive in the same cycle.
- Each strobe lasts one cycle.
- `err_set` carries only one-cycle event pulses that are meaningful at any time.

The bench drives one access per cycle from the falling edge and never raises both strobes together. The unclaimed cases drop the select or misalign the address while keeping a single strobe. The set-versus-clear case lines up one event pulse with a clearing write in the same cycle on purpose.

// File: rtl/cfg_space.sv
module cfg_space #(
  parameter logic [15:0] VENDOR_ID  = 16'h1AB4,
  parameter logic [15:0] DEVICE_ID  = 16'h0C21,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h058000,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [1:0]  SEL_TIMING = 2'b01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_sel,
  input  logic        cfg_rd,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  logic [5:0]  err_set,
  output logic [31:0] cfg_rdata,
  output logic        cfg_ack,
  output logic        io_en,
  output logic        mem_en,
  output logic        master_en,
  output logic        perr_resp_en,
  output logic        serr_en,
  output logic        fn_active
);
  localparam logic [15:0] CMD_MASK = 16'h0147;
  localparam logic [5:0]  DW_ID    = 6'h00;
  localparam logic [5:0]  DW_CMD   = 6'h01;
  localparam logic [5:0]  DW_REV   = 6'h02;
  localparam logic [5:0]  DW_HDR   = 6'h03;
  localparam logic [5:0]  DW_INT   = 6'h0F;

  logic [15:0] cmd;
  logic [5:0]  sts_err;
  logic [7:0]  int_line;
  logic [31:0] rd_mux;

  wire       claim  = cfg_sel && (cfg_addr[1:0] == 2'b00);
  wire       wr_hit = claim && cfg_wr;
  wire       rd_hit = claim && cfg_rd;
  wire [5:0] dw     = cfg_addr[7:2];
  wire       cmd_wr = wr_hit && (dw == DW_CMD);
  wire       int_wr = wr_hit && (dw == DW_INT);

  wire [5:0]  sts_clr  = (cmd_wr && cfg_be[3]) ? {cfg_wdata[31:27], cfg_wdata[24]} : 6'd0;
  wire [15:0] status16 = {sts_err[5:1], SEL_TIMING, sts_err[0], 8'h00};

  assign io_en        = cmd[0];
  assign mem_en       = cmd[1];
  assign master_en    = cmd[2];
  assign perr_resp_en = cmd[6];
  assign serr_en      = cmd[8];
  assign fn_active    = |cmd;

  always_comb begin
    case (dw)
      DW_ID:   rd_mux = {DEVICE_ID, VENDOR_ID};
      DW_CMD:  rd_mux = {status16, cmd};
      DW_REV:  rd_mux = {CLASS_CODE, REV_ID};
      DW_HDR:  rd_mux = {8'h00, HDR_TYPE, 16'h0000};
      DW_INT:  rd_mux = {16'h0000, INT_PIN, int_line};
      default: rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd       <= 16'h0;
      sts_err   <= 6'h0;
      int_line  <= 8'h0;
      cfg_rdata <= 32'h0;
      cfg_ack   <= 1'b0;
    end else begin
      if (cmd_wr && cfg_be[0]) cmd[7:0]  <= cfg_wdata[7:0]  & CMD_MASK[7:0];
      if (cmd_wr && cfg_be[1]) cmd[15:8] <= cfg_wdata[15:8] & CMD_MASK[15:8];
      if (int_wr && cfg_be[0]) int_line  <= cfg_wdata[7:0];
      sts_err <= (sts_err & ~sts_clr) | err_set;
      if (rd_hit) cfg_rdata <= rd_mux;
      cfg_ack <= rd_hit || wr_hit;
    end
  end

  // R1
  no_ack_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !claim |=> !cfg_ack);

  // R7
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != 6'd0) |=> ((sts_err & $past(err_set)) == $past(err_set)));

  // R7
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_err & ~$past(sts_err) & ~$past(err_set)) == 6'd0);

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(cmd));

  // R12
  spare_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && dw >= 6'h10) |=> (cfg_rdata == 32'h0));
endmodule

// File: tb/sim_cfg_space.sv
module sim_cfg_space;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sel = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0]  err_set = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_ack, io_en, mem_en, master_en, perr_resp_en, serr_en, fn_active;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_space u0 (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .err_set(err_set),
    .cfg_rdata(cfg_rdata), .cfg_ack(cfg_ack), .io_en(io_en), .mem_en(mem_en),
    .master_en(master_en), .perr_resp_en(perr_resp_en), .serr_en(serr_en),
    .fn_active(fn_active)
  );

  // {wr, sel, addr, be, wdata, exp_ack, exp_rdata}
  localparam logic [78:0] VEC [0:NV-1] = '{
    {1'b0,1'b1,8'h00,4'hF,32'h0,1'b1,32'h0C211AB4},        // R2
    {1'b0,1'b1,8'h08,4'hF,32'h0,1'b1,32'h05800003},        // R2
    {1'b0,1'b1,8'h0C,4'hF,32'h0,1'b1,32'h00000000},        // R2
    {1'b0,1'b1,8'h04,4'hF,32'h0,1'b1,32'h02000000},        // R6 R10
    {1'b1,1'b1,8'h04,4'h3,32'h0000FFFF,1'b1,32'h0},        // R3
    {1'b0,1'b1,8'h04,4'hF,32'h0,1'b1,32'h02000147},        // R3
    {1'b1,1'b1,8'h04,4'h1,32'h00000000,1'b1,32'h0},        // R3
    {1'b0,1'b1,8'h04,4'hF,32'h0,1'b1,32'h02000100},        // R3
    {1'b1,1'b1,8'h04,4'h2,32'h00000000,1'b1,32'h0},        // R3
    {1'b0,1'b1,8'h04,4'hF,32'h0,1'b1,32'h02000000},        // R3
    {1'b1,1'b1,8'h04,4'hC,32'hFFFF0000,1'b1,32'h0},        // R10
    {1'b0,1'b1,8'h04,4'hF,32'h0,1'b1,32'h02000000},        // R10
    {1'b1,1'b1,8'h00,4'hF,32'hFFFFFFFF,1'b1,32'h0},        // R13
    {1'b0,1'b1,8'h00,4'hF,32'h0,1'b1,32'h0C211AB4},        // R13
    {1'b1,1'b1,8'h08,4'hF,32'hFFFFFFFF,1'b1,32'h0},        // R13
    {1'b0,1'b1,8'h08,4'hF,32'h0,1'b1,32'h05800003},        // R13
    {1'b1,1'b1,8'h3C,4'h3,32'h0000FFA5,1'b1,32'h0},        // R11
    {1'b0,1'b1,8'h3C,4'hF,32'h0,1'b1,32'h000001A5},        // R11
    {1'b1,1'b1,8'h3C,4'h2,32'h0000005A,1'b1,32'h0},        // R11
    {1'b0,1'b1,8'h3C,4'hF,32'h0,1'b1,32'h000001A5},        // R11
    {1'b1,1'b1,8'h40,4'hF,32'hFFFFFFFF,1'b1,32'h0},        // R12
    {1'b0,1'b1,8'h40,4'hF,32'h0,1'b1,32'h0},               // R12
    {1'b0,1'b1,8'hFC,4'hF,32'h0,1'b1,32'h0},               // R12
    {1'b0,1'b1,8'h10,4'hF,32'h0,1'b1,32'h0},               // R12
    {1'b0,1'b0,8'h00,4'hF,32'h0,1'b0,32'h0},               // R1
    {1'b1,1'b1,8'h05,4'h3,32'h0000FFFF,1'b0,32'h0},        // R1
    {1'b1,1'b0,8'h04,4'h3,32'h0000FFFF,1'b0,32'h0},        // R1
    {1'b0,1'b1,8'h04,4'hF,32'h0,1'b1,32'h02000000},        // R1
    {1'b1,1'b1,8'h3E,4'h1,32'h000000FF,1'b0,32'h0},        // R1
    {1'b0,1'b1,8'h3C,4'hF,32'h0,1'b1,32'h000001A5}         // R1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rd, input logic wr, input logic sel, input logic [7:0] a,
                     input logic [3:0] be, input logic [31:0] wd, input logic [5:0] es);
    cfg_rd = rd; cfg_wr = wr; cfg_sel = sel; cfg_addr = a; cfg_be = be;
    cfg_wdata = wd; err_set = es;
    @(negedge clk);
    cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; err_set = '0;
  endtask

  task automatic rd_sts(input string req, input logic [15:0] exp);
    cyc(1'b1, 1'b0, 1'b1, 8'h04, 4'hF, 32'h0, 6'h0);
    chk(req, {16'h0, cfg_rdata[31:16]}, {16'h0, exp});
  endtask

  function automatic logic [31:0] ens();
    return {26'h0, io_en, mem_en, master_en, perr_resp_en, serr_en, fn_active};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6", ens(), 32'h0);
    chk("R6", {31'h0, cfg_ack}, 32'h0);
    chk("R6", cfg_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [78:0] v;
      v = VEC[i];
      cyc(!v[78], v[78], v[77], v[76:69], v[68:65], v[64:33], 6'h0);
      chk($sformatf("vec%0d ack", i), {31'h0, cfg_ack}, {31'h0, v[32]});
      if (!v[78] && v[32]) chk($sformatf("vec%0d data", i), cfg_rdata, v[31:0]);
    end

    // R4 enables mirror command bits
    cyc(1'b0, 1'b1, 1'b1, 8'h04, 4'h3, 32'h0000FFFF, 6'h0);
    chk("R4", ens(), 32'h3F);
    cyc(1'b0, 1'b1, 1'b1, 8'h04, 4'h3, 32'h00000002, 6'h0);
    chk("R4", ens(), 32'h11);
    cyc(1'b0, 1'b1, 1'b1, 8'h04, 4'h3, 32'h00000100, 6'h0);
    chk("R4", ens(), 32'h03);
    // R5 zero command isolates, configuration still claimed
    cyc(1'b0, 1'b1, 1'b1, 8'h04, 4'h3, 32'h00000000, 6'h0);
    chk("R5", ens(), 32'h0);
    cyc(1'b1, 1'b0, 1'b1, 8'h00, 4'hF, 32'h0, 6'h0);
    chk("R5", {31'h0, cfg_ack}, 32'h1);
    chk("R5", cfg_rdata, 32'h0C211AB4);

    // R7 event pulses set flags, sticky
    cyc(1'b0, 1'b0, 1'b0, 8'h00, 4'h0, 32'h0, 6'h3F);
    repeat (2) @(negedge clk);
    rd_sts("R7", 16'hFB00);
    rd_sts("R7", 16'hFB00);
    // R8 write-one-to-clear bits 8 and 11
    cyc(1'b0, 1'b1, 1'b1, 8'h04, 4'h8, 32'h09000000, 6'h0);
    rd_sts("R8", 16'hF200);
    // R8 byte enable 3 low: no clear
    cyc(1'b0, 1'b1, 1'b1, 8'h04, 4'h7, 32'hFF000000, 6'h0);
    rd_sts("R8", 16'hF200);
    // R9 set wins on bit 12; bit 13 clears
    cyc(1'b0, 1'b1, 1'b1, 8'h04, 4'h8, 32'h30000000, 6'h04);
    rd_sts("R9", 16'hD200);
    // R6 reset again clears flags, command and line
    cyc(1'b0, 1'b1, 1'b1, 8'h04, 4'h3, 32'h00000147, 6'h0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R6", ens(), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_sts("R6", 16'h0200);
    cyc(1'b1, 1'b0, 1'b1, 8'h3C, 4'hF, 32'h0, 6'h0);
    chk("R6", cfg_rdata, 32'h00000100);

    finish_run();
  end
endmodule